// File: doc/BRIEF.md
# Best-Three Segment Selector

On every bunch crossing this block takes in eighteen track-segment candidates at the same time. They come from nine upstream sources, and each source supplies two. The block gives each candidate a quality score from a rewritable table. The table is indexed by the candidate's cathode pattern number and anode quality. The block then chooses the three best-scoring valid candidates and sends them downstream. The three chosen records are packed into six 20-bit words, one word for each serial link. A new set of candidates can enter on every clock, and the result appears after a fixed delay.

The block also checks timing. Each candidate carries a five-bit crossing tag, which is compared with a local crossing counter. A separate error flag is raised for each input whose tag does not match. A reduced mode considers only the first sixteen inputs and keeps two winners.

For testing, an input FIFO can replace the live inputs with whole candidate sets loaded earlier. A capture FIFO records output words so the host can read them back in order.

Top module: `seg_best3_sel`

## Requirements

- R1: Candidate record layout:
  - bit 39 is the valid flag;
  - bits 38:37 hold the anode quality;
  - bits 36:29 hold the cathode pattern;
  - bits 28:5 hold position data;
  - bits 4:0 hold the crossing tag.
- R1 (continued): The quality of a candidate is the table entry at index {anode quality, pattern}. A table write at `tbl_addr` ignores address bit 10, so two addresses that differ only in bit 10 reach the same entry. Writes can be made at any time between candidate sets.
- R2: The output slots are filled in order of descending quality. Slot 0 holds the best enabled candidate, slot 1 the next best, and slot 2 the third. Each slot carries the candidate's record unchanged.
- R3: When two qualities are equal, the candidate with the lower input index is placed first.
- R4: A candidate whose valid flag is 0 is never selected. A valid candidate with quality 0 can still be selected. Any slot with no candidate is all zeros.
- R5: When `mode_two` is 1 for a set, inputs 16 and 17 are neither selected nor flagged, and slot 2 is all zeros.
- R6: `bx_err[i]` is 1 when input i is valid, is enabled by the mode, and has a crossing tag different from the local counter value at the edge where the set is sampled.
- R7: The local counter increments by one on every clock (modulo 32). A clock edge with `bx_zero` high loads it with 0 instead.
- R8: `link_frames` is the concatenation {slot 2, slot 1, slot 0}. Link word k occupies bits 20k+19 down to 20k.
- R9: A set sampled at clock edge e appears on `link_frames` and `bx_err` after edge e+2. A new set is accepted on every edge.
- R10: While `test_src` is 1, the live inputs are ignored. Each edge takes the next set from the input FIFO, or an all-invalid set if the FIFO is empty.
- R11: Each edge with `cap_en` high pushes the current `link_frames` into the capture FIFO (depth 4), unless the FIFO is full, in which case the word is dropped. `tout_data` shows the oldest word, and `tout_pop` removes it.
- R12: After reset, `link_frames` and `bx_err` are zero, the capture FIFO is empty and the input FIFO is not full.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per crossing |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_two | input | 1 | Reduced two-of-sixteen selection for the current set |
| bx_zero | input | 1 | Loads the local crossing counter with zero |
| cand_in | input | 720 | Eighteen live candidate records, input i at bits 40i+39:40i |
| tbl_we | input | 1 | Quality table write strobe |
| tbl_addr | input | 11 | Table write address, bit 10 ignored |
| tbl_data | input | 8 | Quality value to write |
| test_src | input | 1 | Take candidate sets from the input FIFO |
| tin_push | input | 1 | Push one set into the input FIFO |
| tin_set | input | 720 | Set to push |
| tin_full | output | 1 | Input FIFO full |
| cap_en | input | 1 | Capture the current output word |
| tout_pop | input | 1 | Remove the oldest captured word |
| tout_data | output | 120 | Oldest captured word |
| tout_empty | output | 1 | Capture FIFO empty |
| link_frames | output | 120 | Six 20-bit link words |
| bx_err | output | 18 | Per-input crossing-tag mismatch flags |

## Verification

The assertions assume four things about the inputs:
- `mode_two` travels with its candidate set;
- `bx_zero` is a level that the counter samples;
- table writes do not overlap the lookup of a set being checked;
- the capture FIFO is popped only through `tout_pop`.

The stimulus respects these assumptions:
- it changes every input half a cycle away from the sampling edge;
- it programs the whole table before any set is streamed;
- it rewrites a single entry only while no candidates are in flight.

Crossing tags are built from the bench's own counter model, so matches and deliberate mismatches can be told apart at every `bx_zero` reload.

// File: rtl/seg_sel_pkg.sv
package seg_sel_pkg;
  localparam int REC_W   = 40;
  localparam int VLD_BIT = 39;
  localparam int AQ_LO   = 37;
  localparam int AQ_W    = 2;
  localparam int PAT_LO  = 29;
  localparam int PAT_W   = 8;
  localparam int BX_LO   = 0;
  localparam int BX_W    = 5;
  localparam int QW      = 8;
  localparam int TA_W    = 11;
  localparam int TI_W    = AQ_W + PAT_W;

  typedef logic [REC_W-1:0] rec_t;
  typedef logic [QW-1:0]    qual_t;

  function automatic logic rec_valid(rec_t r);
    return r[VLD_BIT];
  endfunction

  function automatic logic [TI_W-1:0] rec_tab_idx(rec_t r);
    return {r[AQ_LO +: AQ_W], r[PAT_LO +: PAT_W]};
  endfunction

  function automatic logic [BX_W-1:0] rec_bx(rec_t r);
    return r[BX_LO +: BX_W];
  endfunction

  // a outranks b: higher quality, or equal quality and lower index
  function automatic logic outranks(qual_t qa, int unsigned ia, qual_t qb, int unsigned ib);
    return (qa > qb) || ((qa == qb) && (ia < ib));
  endfunction
endpackage

// File: rtl/seg_qual_tab.sv
module seg_qual_tab
  import seg_sel_pkg::*;
#(
  parameter int NIN = 18
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [TI_W-1:0] wr_idx,
  input  qual_t           wr_q,
  input  rec_t            rd_rec [NIN],
  output qual_t           rd_q   [NIN]
);
  localparam int DEPTH = 1 << TI_W;

  qual_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_q;
  end

  // one registered read port per candidate
  always_ff @(posedge clk) begin
    for (int i = 0; i < NIN; i++) rd_q[i] <= mem[rec_tab_idx(rd_rec[i])];
  end
endmodule

// File: rtl/seg_rank_pick.sv
module seg_rank_pick
  import seg_sel_pkg::*;
#(
  parameter int NIN       = 18,
  parameter int NIN_RED   = 16,
  parameter int NSLOT     = 3,
  parameter int NSLOT_RED = 2
) (
  input  logic           two_mode,
  input  rec_t           rec      [NIN],
  input  qual_t          q        [NIN],
  output logic [NIN-1:0] pick     [NSLOT],
  output rec_t           slot_rec [NSLOT],
  output qual_t          slot_q   [NSLOT]
);
  localparam int RKW = $clog2(NIN + 1);

  logic [NIN-1:0] en;
  logic [RKW-1:0] rank [NIN];

  always_comb begin
    for (int i = 0; i < NIN; i++)
      en[i] = rec_valid(rec[i]) && (!two_mode || (i < NIN_RED));
  end

  // rank of a candidate = number of enabled candidates that outrank it
  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      rank[i] = '0;
      for (int j = 0; j < NIN; j++) begin
        if ((j != i) && en[j] && outranks(q[j], j, q[i], i))
          rank[i] = rank[i] + 1'b1;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NSLOT; k++) begin
      for (int i = 0; i < NIN; i++)
        pick[k][i] = !(two_mode && (k >= NSLOT_RED)) && en[i] && (rank[i] == RKW'(k));
    end
  end

  always_comb begin
    for (int k = 0; k < NSLOT; k++) begin
      slot_rec[k] = '0;
      slot_q[k]   = '0;
      for (int i = 0; i < NIN; i++) begin
        if (pick[k][i]) begin
          slot_rec[k] = slot_rec[k] | rec[i];
          slot_q[k]   = slot_q[k] | q[i];
        end
      end
    end
  end
endmodule

// File: rtl/seg_fifo.sv
module seg_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= ptr_next(wp);
      if (do_pop)  rp <= ptr_next(rp);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/seg_best3_sel.sv
module seg_best3_sel
  import seg_sel_pkg::*;
#(
  parameter int NSRC       = 9,
  parameter int NPER       = 2,
  parameter int NIN_RED    = 16,
  parameter int NSLOT      = 3,
  parameter int NSLOT_RED  = 2,
  parameter int FW         = 20,
  parameter int TIN_DEPTH  = 4,
  parameter int TOUT_DEPTH = 4,
  localparam int NIN       = NSRC * NPER,
  localparam int NLINK     = (NSLOT * REC_W) / FW,
  localparam int SET_W     = NIN * REC_W,
  localparam int OUT_W     = NLINK * FW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_two,
  input  logic              bx_zero,
  input  logic [SET_W-1:0]  cand_in,
  input  logic              tbl_we,
  input  logic [TA_W-1:0]   tbl_addr,
  input  logic [QW-1:0]     tbl_data,
  input  logic              test_src,
  input  logic              tin_push,
  input  logic [SET_W-1:0]  tin_set,
  output logic              tin_full,
  input  logic              cap_en,
  input  logic              tout_pop,
  output logic [OUT_W-1:0]  tout_data,
  output logic              tout_empty,
  output logic [OUT_W-1:0]  link_frames,
  output logic [NIN-1:0]    bx_err
);
  localparam int TLW = $clog2(TIN_DEPTH + 1);
  localparam int OLW = $clog2(TOUT_DEPTH + 1);

  // ---------------- input source selection ----------------
  logic [SET_W-1:0] tin_head;
  logic             tin_empty, tin_pop;
  logic [TLW-1:0]   tin_level;
  logic [SET_W-1:0] src_set;

  assign tin_pop = test_src && !tin_empty;
  assign src_set = test_src ? (tin_empty ? '0 : tin_head) : cand_in;

  seg_fifo #(.W(SET_W), .DEPTH(TIN_DEPTH)) u_tin (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (tin_push),
    .din   (tin_set),
    .pop   (tin_pop),
    .dout  (tin_head),
    .empty (tin_empty),
    .full  (tin_full),
    .level (tin_level)
  );

  rec_t src_rec [NIN];
  for (genvar g = 0; g < NIN; g++) begin : g_unpack
    assign src_rec[g] = src_set[g*REC_W +: REC_W];
  end

  // ---------------- crossing counter ----------------
  logic [BX_W-1:0] bx_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bx_cnt <= '0;
    else if (bx_zero) bx_cnt <= '0;
    else              bx_cnt <= bx_cnt + 1'b1;
  end

  // ---------------- stage 1: sample and tag check ----------------
  rec_t           rec_s1 [NIN];
  logic [NIN-1:0] mism_s1;
  logic           mode_s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NIN; i++) rec_s1[i] <= '0;
      mism_s1 <= '0;
      mode_s1 <= 1'b0;
    end else begin
      for (int i = 0; i < NIN; i++) begin
        rec_s1[i]  <= src_rec[i];
        mism_s1[i] <= rec_valid(src_rec[i]) && (!mode_two || (i < NIN_RED))
                      && (rec_bx(src_rec[i]) != bx_cnt);
      end
      mode_s1 <= mode_two;
    end
  end

  // ---------------- stage 2: quality lookup ----------------
  qual_t          q_s2 [NIN];
  rec_t           rec_s2 [NIN];
  logic [NIN-1:0] mism_s2;
  logic           mode_s2;
  logic [NIN-1:0] vld_s2;

  seg_qual_tab #(.NIN(NIN)) u_tab (
    .clk    (clk),
    .wr_en  (tbl_we),
    .wr_idx (tbl_addr[TI_W-1:0]),
    .wr_q   (tbl_data),
    .rd_rec (rec_s1),
    .rd_q   (q_s2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NIN; i++) rec_s2[i] <= '0;
      mism_s2 <= '0;
      mode_s2 <= 1'b0;
    end else begin
      for (int i = 0; i < NIN; i++) rec_s2[i] <= rec_s1[i];
      mism_s2 <= mism_s1;
      mode_s2 <= mode_s1;
    end
  end

  for (genvar g = 0; g < NIN; g++) begin : g_vld
    assign vld_s2[g] = rec_valid(rec_s2[g]);
  end

  // ---------------- stage 3: ranking and output ----------------
  logic [NIN-1:0] pick [NSLOT];
  rec_t           pick_rec [NSLOT];
  qual_t          pick_q [NSLOT];

  seg_rank_pick #(
    .NIN(NIN), .NIN_RED(NIN_RED), .NSLOT(NSLOT), .NSLOT_RED(NSLOT_RED)
  ) u_rank (
    .two_mode (mode_s2),
    .rec      (rec_s2),
    .q        (q_s2),
    .pick     (pick),
    .slot_rec (pick_rec),
    .slot_q   (pick_q)
  );

  rec_t  slot_rec_o [NSLOT];
  qual_t slot_q_o   [NSLOT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NSLOT; k++) begin
        slot_rec_o[k] <= '0;
        slot_q_o[k]   <= '0;
      end
      bx_err <= '0;
    end else begin
      for (int k = 0; k < NSLOT; k++) begin
        slot_rec_o[k] <= pick_rec[k];
        slot_q_o[k]   <= pick_q[k];
      end
      bx_err <= mism_s2;
    end
  end

  // named wires for the checker
  logic [NSLOT*QW-1:0]  slot_q_flat;
  logic [NSLOT*NIN-1:0] pick_flat;
  for (genvar k = 0; k < NSLOT; k++) begin : g_pack
    assign link_frames[k*REC_W +: REC_W] = slot_rec_o[k];
    assign slot_q_flat[k*QW +: QW]       = slot_q_o[k];
    assign pick_flat[k*NIN +: NIN]       = pick[k];
  end

  // ---------------- capture FIFO ----------------
  logic [OLW-1:0] tout_level;
  logic           tout_full;

  seg_fifo #(.W(OUT_W), .DEPTH(TOUT_DEPTH)) u_tout (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (cap_en),
    .din   (link_frames),
    .pop   (tout_pop),
    .dout  (tout_data),
    .empty (tout_empty),
    .full  (tout_full),
    .level (tout_level)
  );
endmodule

// File: rtl/seg_best3_chk.sv
module seg_best3_chk
  import seg_sel_pkg::*;
#(
  parameter int NIN        = 18,
  parameter int NSLOT      = 3,
  parameter int NLINK      = 6,
  parameter int FW         = 20,
  parameter int TIN_DEPTH  = 4,
  parameter int TOUT_DEPTH = 4,
  localparam int TLW       = $clog2(TIN_DEPTH + 1),
  localparam int OLW       = $clog2(TOUT_DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bx_zero,
  input logic                 mode_two,
  input logic [NLINK*FW-1:0]  link_frames,
  input logic [NIN-1:0]       bx_err,
  input logic [BX_W-1:0]      bx_cnt,
  input logic [NIN-1:0]       vld_s2,
  input logic [NSLOT*QW-1:0]  slot_q_flat,
  input logic [NSLOT*NIN-1:0] pick_flat,
  input logic [OLW-1:0]       tout_level,
  input logic                 tout_pop,
  input logic                 cap_en,
  input logic [TLW-1:0]       tin_level,
  input logic                 tin_push,
  input logic                 test_src
);
  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    // R4: an empty slot is driven as zeros
    p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !link_frames[k*REC_W + VLD_BIT] |-> (link_frames[k*REC_W +: REC_W] == '0));
    // R2: at most one candidate lands in each slot
    p_one_pick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pick_flat[k*NIN +: NIN]));
    if (k > 0) begin : g_ord
      // R2: slots ordered by descending quality, filled from slot 0
      p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        link_frames[k*REC_W + VLD_BIT] |->
          (link_frames[(k-1)*REC_W + VLD_BIT] &&
           (slot_q_flat[(k-1)*QW +: QW] >= slot_q_flat[k*QW +: QW])));
      // R2: no candidate is picked for two slots
      p_disjoint_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_flat[k*NIN +: NIN] & pick_flat[(k-1)*NIN +: NIN]) == '0);
    end
  end

  // R5: a set sampled in reduced mode leaves slot 2 empty
  p_two_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_two, 3) |-> (link_frames[2*REC_W +: REC_W] == '0));

  // R6: a flag only comes from a valid candidate
  p_err_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bx_err & ~$past(vld_s2)) == '0);

  // R7: counter steps by one without a reload
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bx_zero)) |-> (bx_cnt == BX_W'($past(bx_cnt) + 1'b1)));

  // R7: reload forces zero
  p_count_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bx_zero)) |-> (bx_cnt == '0));

  // R11: a full capture FIFO stays full until popped
  p_full_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((tout_level == OLW'(TOUT_DEPTH)) && !tout_pop) |=> (tout_level == OLW'(TOUT_DEPTH)));

  // R11: capture into a non-full FIFO raises the level when not popped
  p_cap_grow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !tout_pop && (tout_level < OLW'(TOUT_DEPTH))) |=> (tout_level == $past(tout_level) + 1'b1));

  // R10: injection drains one set per clock
  p_inject_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (test_src && !tin_push && (tin_level != '0)) |=> (tin_level == $past(tin_level) - 1'b1));
endmodule

bind seg_best3_sel seg_best3_chk #(
  .NIN(NIN), .NSLOT(NSLOT), .NLINK(NLINK), .FW(FW),
  .TIN_DEPTH(TIN_DEPTH), .TOUT_DEPTH(TOUT_DEPTH)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bx_zero     (bx_zero),
  .mode_two    (mode_two),
  .link_frames (link_frames),
  .bx_err      (bx_err),
  .bx_cnt      (bx_cnt),
  .vld_s2      (vld_s2),
  .slot_q_flat (slot_q_flat),
  .pick_flat   (pick_flat),
  .tout_level  (tout_level),
  .tout_pop    (tout_pop),
  .cap_en      (cap_en),
  .tin_level   (tin_level),
  .tin_push    (tin_push),
  .test_src    (test_src)
);

// File: tb/sim_seg_best3_sel.sv
module sim_seg_best3_sel;
  localparam int NIN = 18;
  localparam int RW  = 40;
  localparam int SW  = NIN * RW;
  localparam int OW  = 120;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_two = 1'b0, bx_zero = 1'b0;
  logic [SW-1:0] cand_in = '0;
  logic          tbl_we = 1'b0;
  logic [10:0]   tbl_addr = '0;
  logic [7:0]    tbl_data = '0;
  logic          test_src = 1'b0, tin_push = 1'b0;
  logic [SW-1:0] tin_set = '0;
  logic          tin_full;
  logic          cap_en = 1'b0, tout_pop = 1'b0;
  logic [OW-1:0] tout_data;
  logic          tout_empty;
  logic [OW-1:0] link_frames;
  logic [NIN-1:0] bx_err;

  always #10 clk = ~clk;

  seg_best3_sel u0 (
    .clk(clk), .rst_n(rst_n), .mode_two(mode_two), .bx_zero(bx_zero),
    .cand_in(cand_in), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .test_src(test_src), .tin_push(tin_push), .tin_set(tin_set), .tin_full(tin_full),
    .cap_en(cap_en), .tout_pop(tout_pop), .tout_data(tout_data), .tout_empty(tout_empty),
    .link_frames(link_frames), .bx_err(bx_err)
  );

  int checks = 0, errors = 0;
  logic [7:0] tbl [1024];
  logic [4:0] mcnt;
  logic [31:0] lf = 32'h1234_5679;

  // bench copy of the crossing counter (R7)
  always @(posedge clk or negedge rst_n)
    if (!rst_n) mcnt <= '0;
    else        mcnt <= bx_zero ? 5'd0 : mcnt + 5'd1;

  task automatic chk(input bit ok, input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] qf(int a);
    return 8'((a * 73) ^ (a >> 5));
  endfunction

  function automatic logic [31:0] rnd();
    lf = lf ^ (lf << 13);
    lf = lf ^ (lf >> 17);
    lf = lf ^ (lf << 5);
    return lf;
  endfunction

  function automatic logic [RW-1:0] mkrec(logic v, logic [1:0] aq, logic [7:0] pat, logic [23:0] pos, logic [4:0] tag);
    return {v, aq, pat, pos, tag};
  endfunction

  function automatic logic [7:0] q_of(logic [RW-1:0] r);
    return tbl[{r[38:37], r[36:29]}];
  endfunction

  // reference selection: repeated maximum search, strict > keeps lower index
  function automatic logic [OW-1:0] model_sel(logic [SW-1:0] s, logic two);
    logic [OW-1:0] f = '0;
    bit used [NIN];
    int nsl = two ? 2 : 3;
    for (int i = 0; i < NIN; i++) used[i] = 0;
    for (int k = 0; k < nsl; k++) begin
      int best = -1;
      for (int i = 0; i < NIN; i++) begin
        logic [RW-1:0] r = s[i*RW +: RW];
        if (r[39] && (!two || i < 16) && !used[i])
          if (best < 0 || q_of(r) > q_of(s[best*RW +: RW])) best = i;
      end
      if (best >= 0) begin
        f[k*RW +: RW] = s[best*RW +: RW];
        used[best] = 1;
      end
    end
    return f;
  endfunction

  function automatic logic [NIN-1:0] model_err(logic [SW-1:0] s, logic two, logic [4:0] cnt);
    logic [NIN-1:0] e = '0;
    for (int i = 0; i < NIN; i++) begin
      logic [RW-1:0] r = s[i*RW +: RW];
      e[i] = r[39] && (!two || i < 16) && (r[4:0] != cnt);
    end
    return e;
  endfunction

  logic [SW-1:0] gs;
  logic gtwo, gbz;

  task automatic gen(input int kind, input int n);
    gs = '0; gtwo = 1'b0; gbz = 1'b0;
    case (kind)
      0: begin // random sets, both modes, random reloads and mismatches
        logic [31:0] a = rnd();
        gtwo = a[5];
        gbz  = (a[11:8] == 4'd0);
        for (int i = 0; i < NIN; i++) begin
          logic [31:0] x = rnd();
          logic [31:0] y = rnd();
          logic v = (n % 4 == 0) ? (x[3:0] == 4'd0) : (x[1:0] != 2'd0);
          logic [4:0] t = (y[2:0] == 3'd0) ? mcnt + 5'd1 : mcnt;
          gs[i*RW +: RW] = mkrec(v, x[5:4], x[13:6], y[31:8], t);
        end
      end
      1: begin // one valid input walks across all indices
        logic [31:0] x = rnd();
        gtwo = ((n / NIN) % 2) == 1;
        gs[(n % NIN)*RW +: RW] = mkrec(1'b1, x[1:0], x[9:2], x[31:8], mcnt);
      end
      2: begin // equal patterns on every input, random valid mask
        logic [31:0] x = rnd();
        gtwo = (n % 3) == 0;
        for (int i = 0; i < NIN; i++) begin
          logic [31:0] y = rnd();
          gs[i*RW +: RW] = mkrec(y[0] | y[1], 2'(n), 8'(n * 7), y[31:8], mcnt);
        end
        if (x[0]) gs[17*RW + 39] = 1'b1;
      end
      3: begin // valid quality-zero vs invalid high entries
        for (int i = 0; i < NIN; i++)
          gs[i*RW +: RW] = mkrec(1'b0, 2'd3, 8'hFF, 24'hABCDEF, mcnt);
        gs[5*RW +: RW] = mkrec(1'b1, 2'd0, 8'd0, 24'h000505, mcnt);
        gs[9*RW +: RW] = mkrec(1'b1, 2'd0, 8'd0, 24'h000909, mcnt);
      end
      default: begin // aliased table rewrite reaches input 17
        for (int i = 0; i < NIN; i++) begin
          logic [31:0] y = rnd();
          gs[i*RW +: RW] = mkrec(1'b1, y[1:0], y[9:2], y[31:8], mcnt);
        end
        gs[17*RW +: RW] = mkrec(1'b1, 2'd1, 8'h55, 24'h171717, mcnt);
      end
    endcase
  endtask

  logic [OW-1:0]  ef [512];
  logic [NIN-1:0] ee [512];

  // streamed sets: result of set n is checked three negedges later (R9)
  task automatic run_stream(input int kind, input int cnt, input string req);
    for (int n = 0; n < cnt + 3; n++) begin
      @(negedge clk);
      if (n >= 3) begin
        chk(link_frames == ef[n-3], req, link_frames, ef[n-3]);
        chk(bx_err == ee[n-3], "R6", OW'(bx_err), OW'(ee[n-3]));
      end
      if (n < cnt) begin
        gen(kind, n);
        ef[n] = model_sel(gs, gtwo);
        ee[n] = model_err(gs, gtwo, mcnt);
        cand_in = gs; mode_two = gtwo; bx_zero = gbz;
      end else begin
        cand_in = '0; mode_two = 1'b0; bx_zero = 1'b0;
      end
    end
  endtask

  logic [OW-1:0] capx [4];
  logic [SW-1:0] sa, sb;
  logic [OW-1:0] ea, eb;
  logic [NIN-1:0] era, erb;

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R12: reset state
    chk(link_frames == '0, "R12", link_frames, '0);
    chk(bx_err == '0, "R12", OW'(bx_err), '0);
    chk(tout_empty == 1'b1 && tin_full == 1'b0, "R12", OW'({tout_empty, tin_full}), OW'(2'b10));
    rst_n = 1'b1;

    // R1: program the whole table, bit 10 toggled to exercise aliasing
    for (int a = 0; a < 1024; a++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = {a[0], 10'(a)}; tbl_data = qf(a); tbl[a] = qf(a);
    end
    @(negedge clk); tbl_we = 1'b0;
    repeat (2) @(negedge clk);

    run_stream(1, 72, "R8");   // R4 R8 R9 each index alone, both modes
    run_stream(2, 40, "R3");   // ties resolve to lower index
    run_stream(3, 1, "R4");    // valid quality zero chosen over invalid
    run_stream(0, 300, "R2");  // R2 R5 R6 R7 random traffic

    // R1: rewrite one entry through the aliased address
    @(negedge clk); tbl_we = 1'b1; tbl_addr = 11'h555; tbl_data = 8'hFF; tbl[10'h155] = 8'hFF;
    @(negedge clk); tbl_we = 1'b0;
    run_stream(4, 4, "R1");

    // R10: injected sets replace live inputs
    gen(0, 1); sa = gs; gen(0, 2); sb = gs;
    @(negedge clk); tin_push = 1'b1; tin_set = sa;
    @(negedge clk); tin_set = sb;
    @(negedge clk); tin_push = 1'b0; test_src = 1'b1; mode_two = 1'b0; bx_zero = 1'b0;
    gen(4, 0); cand_in = gs;
    ea = model_sel(sa, 1'b0); era = model_err(sa, 1'b0, mcnt);
    @(negedge clk); eb = model_sel(sb, 1'b0); erb = model_err(sb, 1'b0, mcnt);
    @(negedge clk);
    @(negedge clk); test_src = 1'b0; cand_in = '0;
    chk(link_frames == ea, "R10", link_frames, ea);
    chk(bx_err == era, "R10", OW'(bx_err), OW'(era));
    @(negedge clk);
    chk(link_frames == eb, "R10", link_frames, eb);
    chk(bx_err == erb, "R10", OW'(bx_err), OW'(erb));
    @(negedge clk);
    chk(link_frames == '0 && bx_err == '0, "R10", link_frames, '0);

    // R11: capture A, B, then C three times into a depth-4 FIFO
    for (int s = 0; s < 3; s++) begin
      @(negedge clk); gen(0, s * 4 + 1); cand_in = gs; mode_two = 1'b0; bx_zero = 1'b0;
      capx[s] = model_sel(gs, 1'b0);
      repeat (3) @(negedge clk);
      cap_en = 1'b1;
      repeat ((s == 2) ? 3 : 1) @(negedge clk);
      cap_en = 1'b0;
    end
    capx[3] = capx[2];
    chk(tout_empty == 1'b0, "R11", OW'(tout_empty), '0);
    for (int r = 0; r < 4; r++) begin
      chk(tout_data == capx[r], "R11", tout_data, capx[r]);
      tout_pop = 1'b1;
      @(negedge clk);
    end
    tout_pop = 1'b0;
    chk(tout_empty == 1'b1, "R11", OW'(tout_empty), OW'(1));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule